// File: doc/BRIEF.md
# Per-Column Adaptive Ramp Chooser

Each column of a single-slope readout holds one copy of this logic. Before a signal conversion starts, the chooser connects the comparator to the widest, lowest-gain ramp. During a selection window, the first low-to-high change of the comparator shows how far the pixel has swung. At that moment the chooser samples three swing-index levels, which the shared ramp timing drives. These three bits fix which of four shared ramps the column uses for the remaining passes of the conversion. A small swing (dark pixel) lands on a narrow, high-gain ramp that is sampled many times. A large swing stays on the wide ramp.

The captured code is frozen until the next per-row reset. The chooser drives three outputs from that code:
- a one-hot switch select for the four ramps;
- a 2-bit ramp number, which the counter logic uses when it post-processes the result;
- a one-cycle pulse when the column has moved off the default ramp, which the counter uses to restart its count.

A code that cannot come from a monotonic set of index levels raises an error flag and keeps the column on the default ramp.

Top module: `ramp_pick_col`

## Requirements
- R1: While reset is high, and on the first cycle after it, the outputs show ramp number 0, select 4'b0001, no error and no pulse.
- R2: The captured code is {index1, index2, index3}, with index1 as bit 2. The codes 3'b000, 3'b100, 3'b110 and 3'b111 select ramp numbers 0, 1, 2 and 3.
- R3: The code 3'b011 selects ramp number 1 without raising the error flag.
- R4: Each of the codes 3'b001, 3'b010 and 3'b101 selects ramp number 0 and raises the error flag.
- R5: A capture happens only on a low-to-high change of the synchronised comparator while the window input is high. With no such change inside the window, ramp number 0 stays selected and the error flag stays low.
- R6: After the first capture, the selection is frozen until reset. Later comparator changes and index changes do not alter it.
- R7: The switched pulse is high for exactly one cycle after a capture that picks a ramp number other than 0. It never goes high when the capture picks ramp 0.
- R8: The select output always has exactly one bit set. That bit's position equals the ramp number.
- R9: A comparator rise applied between clock edges shows at the outputs after the fourth rising edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column logic clock |
| rst | input | 1 | Synchronous active-high per-row reset |
| cmp_out | input | 1 | Asynchronous comparator output |
| swing_idx | input | 3 | Swing index levels, bit 2 = index1 |
| sel_win | input | 1 | Selection-phase window |
| ramp_sel | output | 4 | One-hot ramp switch select |
| ramp_num | output | 2 | Selected ramp number 0..3 |
| ramp_switched | output | 1 | One-cycle pulse when the column leaves ramp 0 |
| code_err | output | 1 | Captured code was not a legal swing pattern |

## Verification
The bench covers all eight capture codes. A decoder that treated 3'b011 as illegal, or let an illegal code through to a narrow ramp, would show the wrong ramp number or error state. It raises the comparator a second time after changing the index levels; a chooser that was not frozen would move to the new ramp. It also raises the comparator while the window is closed and then opens the window. A design that captured on level instead of on the edge would pick a ramp there. The bench checks the outputs one edge before and at the expected update. A missing or extra synchroniser stage therefore moves the change outside the checked cycle.

// File: rtl/ramp_pick_pkg.sv
package ramp_pick_pkg;

  // Number of leading ones of code c (width w), counted from the MSB.
  function automatic int lead_ones(input int c, input int w);
    int n;
    n = 0;
    for (int i = w - 1; i >= 0; i--) begin
      if (((c >> i) & 1) == 1 && n == (w - 1 - i)) n++;
    end
    return n;
  endfunction

  // True when the code is a legal MSB-first thermometer pattern.
  function automatic bit is_thermo(input int c, input int w);
    int n;
    n = lead_ones(c, w);
    return c == (((1 << w) - 1) ^ ((1 << (w - n)) - 1));
  endfunction

  // The mirrored pattern (ones filled from the LSB, MSB clear) is accepted
  // as the first narrowed ramp.
  function automatic bit is_alias(input int c, input int w);
    return c == ((1 << (w - 1)) - 1);
  endfunction

  function automatic int ramp_of(input int c, input int w);
    if (is_thermo(c, w)) return lead_ones(c, w);
    if (is_alias(c, w))  return 1;
    return 0;
  endfunction

  function automatic bit code_bad(input int c, input int w);
    return !is_thermo(c, w) && !is_alias(c, w);
  endfunction

endpackage

// File: rtl/rp_sync_edge.sv
module rp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sh;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= sh[STAGES-1];
  end

  assign rise_o = sh[STAGES-1] & ~last;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R5

endmodule

// File: rtl/rp_swing_latch.sv
module rp_swing_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic         win,
  input  logic [W-1:0] idx_in,
  output logic [W-1:0] code_o,
  output logic         locked_o,
  output logic         took_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_o   <= '0;
      locked_o <= 1'b0;
      took_o   <= 1'b0;
    end else begin
      took_o <= 1'b0;
      if (fire && win && !locked_o) begin
        code_o   <= idx_in;
        locked_o <= 1'b1;
        took_o   <= 1'b1;
      end
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> locked_o); // R6
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> $stable(code_o)); // R6
  AST_NO_CAPTURE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (!win && !locked_o) |=> !locked_o); // R5

endmodule

// File: rtl/rp_ramp_decode.sv
module rp_ramp_decode
  import ramp_pick_pkg::*;
#(
  parameter int W    = 3,
  parameter int IDXW = 2
) (
  input  logic [W-1:0]    code,
  output logic [IDXW-1:0] idx_o,
  output logic            err_o
);
  localparam int NCODE = 1 << W;

  logic [NCODE-1:0] hot;

  generate
    for (genvar c = 0; c < NCODE; c++) begin : g_dec
      assign hot[c] = (code == W'(c));
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    err_o = 1'b0;
    for (int c = 0; c < NCODE; c++) begin
      if (hot[c]) begin
        idx_o = idx_o | IDXW'(ramp_of(c, W));
        err_o = err_o | code_bad(c, W);
      end
    end
  end

endmodule

// File: rtl/ramp_pick_col.sv
module ramp_pick_col #(
  parameter int IDX_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NRAMP      = IDX_W + 1,
  localparam int NUM_W      = $clog2(NRAMP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_out,
  input  logic [IDX_W-1:0] swing_idx,
  input  logic             sel_win,
  output logic [NRAMP-1:0] ramp_sel,
  output logic [NUM_W-1:0] ramp_num,
  output logic             ramp_switched,
  output logic             code_err
);
  logic             rise;
  logic [IDX_W-1:0] code;
  logic             locked;
  logic             took;
  logic [NUM_W-1:0] dec_num;
  logic             dec_err;
  logic [NRAMP-1:0] sel_next;

  rp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(cmp_out), .rise_o(rise)
  );

  rp_swing_latch #(.W(IDX_W)) u_latch (
    .clk(clk), .rst(rst), .fire(rise), .win(sel_win), .idx_in(swing_idx),
    .code_o(code), .locked_o(locked), .took_o(took)
  );

  rp_ramp_decode #(.W(IDX_W), .IDXW(NUM_W)) u_dec (
    .code(code), .idx_o(dec_num), .err_o(dec_err)
  );

  generate
    for (genvar g = 0; g < NRAMP; g++) begin : g_sel
      assign sel_next[g] = (dec_num == NUM_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_num      <= '0;
      ramp_sel      <= NRAMP'(1);
      code_err      <= 1'b0;
      ramp_switched <= 1'b0;
    end else begin
      ramp_num      <= dec_num;
      ramp_sel      <= sel_next;
      code_err      <= dec_err & locked;
      ramp_switched <= took & (dec_num != '0);
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(ramp_sel)); // R8
  AST_SEL_MATCHES_NUM: assert property (@(posedge clk) disable iff (rst)
    ramp_sel[ramp_num]); // R8
  AST_ERR_DEFAULT_RAMP: assert property (@(posedge clk) disable iff (rst)
    code_err |-> (ramp_num == '0)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ramp_switched |=> !ramp_switched); // R7
  AST_PULSE_NOT_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    ramp_switched |-> (ramp_num != '0)); // R7
  AST_HOLD_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |=> $stable(ramp_num)); // R6

endmodule

// File: tb/ramp_pick_col_test.sv
`timescale 1ns/1ps
module ramp_pick_col_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_out = 1'b0;
  logic [2:0] swing_idx = 3'b000;
  logic       sel_win = 1'b0;
  logic [3:0] ramp_sel;
  logic [1:0] ramp_num;
  logic       ramp_switched;
  logic       code_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ramp_pick_col uut (
    .clk(clk), .rst(rst), .cmp_out(cmp_out), .swing_idx(swing_idx),
    .sel_win(sel_win), .ramp_sel(ramp_sel), .ramp_num(ramp_num),
    .ramp_switched(ramp_switched), .code_err(code_err)
  );

  // {code[2:0], window, expected ramp[1:0], expected error}
  localparam logic [6:0] VEC [0:9] = '{
    {3'b000, 1'b1, 2'd0, 1'b0},
    {3'b100, 1'b1, 2'd1, 1'b0},
    {3'b110, 1'b1, 2'd2, 1'b0},
    {3'b111, 1'b1, 2'd3, 1'b0},
    {3'b011, 1'b1, 2'd1, 1'b0},
    {3'b001, 1'b1, 2'd0, 1'b1},
    {3'b010, 1'b1, 2'd0, 1'b1},
    {3'b101, 1'b1, 2'd0, 1'b1},
    {3'b111, 1'b0, 2'd0, 1'b0},
    {3'b110, 1'b0, 2'd0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmp_out = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_case(input logic [2:0] code, input logic win,
                          input logic [1:0] exp_num, input logic exp_err);
    int sw_cnt;
    do_reset();
    swing_idx = code;
    sel_win   = win;
    repeat (3) @(negedge clk);
    cmp_out = 1'b1;
    sw_cnt  = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      sw_cnt += int'(ramp_switched);
      if (i == 3) check(ramp_num == 2'd0, "R9 early", ramp_num, 0);
      if (i == 4) check(ramp_num == exp_num, "R9 on time", ramp_num, exp_num);
    end
    if (exp_err)       check(ramp_num == exp_num, "R4 ramp", ramp_num, exp_num);
    else if (!win)     check(ramp_num == exp_num, "R5 ramp", ramp_num, exp_num);
    else if (code == 3'b011) check(ramp_num == exp_num, "R3 ramp", ramp_num, exp_num);
    else               check(ramp_num == exp_num, "R2 ramp", ramp_num, exp_num);
    check(code_err == exp_err, "R4 err", code_err, exp_err);
    check(ramp_sel == (4'b0001 << exp_num), "R8 select", ramp_sel, 4'b0001 << exp_num);
    check(sw_cnt == ((win && exp_num != 0) ? 1 : 0), "R7 pulse count", sw_cnt,
          (win && exp_num != 0) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(ramp_num == 2'd0 && ramp_sel == 4'b0001, "R1 in reset", ramp_sel, 1);
    rst = 1'b0;
    @(negedge clk);
    check(ramp_num == 2'd0 && ramp_sel == 4'b0001 && !code_err && !ramp_switched,
          "R1 after reset", {ramp_num, ramp_sel}, 1);

    for (int v = 0; v < 10; v++)
      run_case(VEC[v][6:4], VEC[v][3], VEC[v][2:1], VEC[v][0]);

    // R6: frozen after capture, later flips and index changes ignored
    run_case(3'b100, 1'b1, 2'd1, 1'b0);
    swing_idx = 3'b111;
    cmp_out = 1'b0;
    repeat (4) @(negedge clk);
    cmp_out = 1'b1;
    repeat (8) @(negedge clk);
    check(ramp_num == 2'd1, "R6 frozen", ramp_num, 1);
    check(!ramp_switched, "R6 no new pulse", ramp_switched, 0);

    // R1: reset clears a held selection
    rst = 1'b1;
    @(negedge clk);
    check(ramp_num == 2'd0 && ramp_sel == 4'b0001, "R1 clears", ramp_num, 0);

    // R5: rise while window closed, window opens later with comparator high
    do_reset();
    swing_idx = 3'b111;
    sel_win = 1'b0;
    repeat (2) @(negedge clk);
    cmp_out = 1'b1;
    repeat (6) @(negedge clk);
    sel_win = 1'b1;
    repeat (6) @(negedge clk);
    check(ramp_num == 2'd0, "R5 level not edge", ramp_num, 0);
    check(!code_err, "R5 no err", code_err, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule